// File: doc/BRIEF.md
# Cascaded Eight-Input Interrupt Controller Pair

This block holds two eight-input interrupt controllers on a small 8-bit port bus. One is the primary and one the secondary, and both sit behind a single vector output. Each controller latches request pulses into a pending register and filters them through its own mask. It picks the unmasked request with the lowest index and offers a vector built from a programmed base plus that index. The secondary reaches the CPU through the primary's input 7. That input is not a latched wire: it is the live summary "the secondary has something unmasked pending".

Software sets up each controller with a start word on the low port and then three words on the high port. The first of those three words is the vector base. Once the sequence is over, high-port writes load the mask. Low-port writes whose bit 4 is clear either pick which status register a low-port read returns (when bit 3 is set) or are taken and ignored (when bit 3 is clear). The vector leaves the block through a valid/ready handshake. The request that is chosen is cleared from its latch at the moment it is issued.

On the secondary, inputs 1 to 3 are meant for the three timer channels and inputs 6 and 7 for serial transmit-ready and receive-ready. That wiring is done by the integrator.

Top module: `irq_pair_ctrl`

## Requirements
- R1: After reset both masks read 0xFF, low-port reads return 0xFF and `vec_valid` is low.
- R2: A low-port write with bit 4 set starts a setup sequence. The next three high-port writes are setup words: the first of them is the vector base, and none of them changes the mask. After the third, high-port writes load the mask again.
- R3: A low-port write with bit 4 clear and bit 3 set stores bits 1:0 as the status select. With bits 4 and 3 both clear the write changes no readable state.
- R4: A low-port read returns the latched-request register when the status select is 2'b11. It returns the in-flight register (one-hot of the input whose vector is being offered) when the select is 2'b10, and 0xFF otherwise. Port addresses: 0 is primary low, 1 primary high, 2 secondary low, 3 secondary high. A high-port read returns the mask.
- R5: A request pulse is latched and stays latched while its mask bit is 1. A masked request never produces a vector.
- R6: Among unmasked latched requests, the lowest index wins.
- R7: The vector equals base plus index modulo 256. The winning request is cleared from the latch in the same cycle the vector is loaded.
- R8: Primary input 7 is the secondary's unmasked-pending summary. Primary inputs 0 to 6 beat it. When it wins, the vector comes from the secondary's base and winner, and a primary mask bit 7 of 1 blocks the whole secondary.
- R9: `vec_data` is held stable while `vec_valid` is high and `vec_ready` low. After an accept, `vec_valid` is low for exactly one cycle before the next pending vector appears.
- R10: Unmasking a latched request makes it issue on the following cycle, with no new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Bit 1 selects the secondary, bit 0 selects the high port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_m | input | 7 | Request pulses for primary inputs 0 to 6 |
| irq_s | input | 8 | Request pulses for secondary inputs 0 to 7 |
| vec_ready | input | 1 | Consumer accepts the offered vector |
| vec_valid | output | 1 | A vector is offered |
| vec_data | output | 8 | Offered vector |

## Verification
The bench aims at the priority cases. A primary input 6 must beat a secondary request, which a design that ranked the cascade input by latch instead of by index would get wrong. A primary mask bit 7 must silence the whole secondary, which a design that read the secondary directly would let through. It also checks that high-port writes in the middle of a setup sequence leave the mask alone; a counter that ended one word early would corrupt the mask. Further checks cover base-plus-index wrap-around, masked requests that survive in the latch and issue as soon as they are unmasked, and the single idle cycle after an accept. That idle cycle catches a design that either drops the second request or repeats the first.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int DW    = 8;
  localparam int NIN   = 8;
  localparam int IW    = $clog2(NIN);
  localparam int ADDRW = 2;

  typedef struct packed {
    logic          hit;
    logic [IW-1:0] idx;
  } pick_t;

  function automatic pick_t pick_lowest(input logic [NIN-1:0] v);
    pick_t p;
    p.hit = 1'b0;
    p.idx = '0;
    for (int i = NIN - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.hit = 1'b1;
        p.idx = IW'(i);
      end
    end
    return p;
  endfunction

  function automatic logic [DW-1:0] make_vector(input logic [DW-1:0] base,
                                                input logic [IW-1:0] idx);
    return base + DW'(idx);
  endfunction

  function automatic logic [NIN-1:0] one_hot(input logic [IW-1:0] idx);
    return NIN'(1) << idx;
  endfunction
endpackage

// File: rtl/irq_unit.sv
module irq_unit
  import irqp_pkg::*;
#(
  parameter bit HAS_CASC = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [DW-1:0]  wdata,
  input  logic [NIN-1:0] req_in,
  input  logic           casc_req,
  input  logic [NIN-1:0] clr,
  input  logic [NIN-1:0] inflight,
  output logic [DW-1:0]  rd_lo,
  output logic [DW-1:0]  rd_hi,
  output logic           pend_any,
  output logic [IW-1:0]  win_idx,
  output logic [DW-1:0]  base_o,
  output logic [NIN-1:0] mask_o,
  output logic [NIN-1:0] latch_o
);
  localparam logic [1:0] SEL_LATCH = 2'b11;
  localparam logic [1:0] SEL_FLIGHT = 2'b10;
  localparam logic [1:0] CNT_LAST = 2'd3;

  logic [1:0]     cfg_cnt;
  logic [1:0]     stat_sel;
  logic [DW-1:0]  base_q;
  logic [NIN-1:0] mask_q;
  logic [NIN-1:0] latch_q;
  logic           cfg_active;
  logic           is_start;
  logic           is_select;
  logic [NIN-1:0] casc_vec;
  logic [NIN-1:0] pending;
  pick_t          pick;

  assign cfg_active = (cfg_cnt != 2'd0);
  assign is_start   = wdata[4];
  assign is_select  = !wdata[4] && wdata[3];

  generate
    if (HAS_CASC) begin : g_casc
      assign casc_vec = {casc_req, {(NIN-1){1'b0}}};
    end else begin : g_nocasc
      assign casc_vec = {NIN{casc_req & 1'b0}};
    end
  endgenerate

  assign pending  = (latch_q | casc_vec) & ~mask_q;
  assign pick     = pick_lowest(pending);
  assign pend_any = pick.hit;
  assign win_idx  = pick.idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_cnt  <= 2'd0;
      stat_sel <= 2'b00;
      base_q   <= '0;
      mask_q   <= '1;
      latch_q  <= '0;
    end else begin
      latch_q <= (latch_q & ~clr) | req_in;
      if (wr_lo) begin
        if (is_start)       cfg_cnt  <= 2'd1;
        else if (is_select) stat_sel <= wdata[1:0];
      end
      if (wr_hi) begin
        if (!cfg_active) begin
          mask_q <= wdata;
        end else begin
          if (cfg_cnt == 2'd1) base_q <= wdata;
          cfg_cnt <= (cfg_cnt == CNT_LAST) ? 2'd0 : cfg_cnt + 2'd1;
        end
      end
    end
  end

  always_comb begin
    unique case (stat_sel)
      SEL_LATCH:  rd_lo = latch_q;
      SEL_FLIGHT: rd_lo = inflight;
      default:    rd_lo = '1;
    endcase
  end

  assign rd_hi   = mask_q;
  assign base_o  = base_q;
  assign mask_o  = mask_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/vec_issue.sv
module vec_issue
  import irqp_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           m_any,
  input  logic [IW-1:0]  m_idx,
  input  logic [DW-1:0]  m_base,
  input  logic [IW-1:0]  s_idx,
  input  logic [DW-1:0]  s_base,
  input  logic           vec_ready,
  output logic           vec_valid,
  output logic [DW-1:0]  vec_data,
  output logic           take,
  output logic [NIN-1:0] clr_m,
  output logic [NIN-1:0] clr_s,
  output logic [NIN-1:0] irr_m,
  output logic [NIN-1:0] irr_s
);
  localparam logic [IW-1:0] CASC_IDX = IW'(NIN - 1);

  logic          to_slave;
  logic          accept;
  logic [DW-1:0] next_vec;

  assign take     = !vec_valid && m_any;
  assign accept   = vec_valid && vec_ready;
  assign to_slave = (m_idx == CASC_IDX);
  assign next_vec = to_slave ? make_vector(s_base, s_idx) : make_vector(m_base, m_idx);
  assign clr_m    = (take && !to_slave) ? one_hot(m_idx) : '0;
  assign clr_s    = (take && to_slave)  ? one_hot(s_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
      irr_m     <= '0;
      irr_s     <= '0;
    end else if (accept) begin
      vec_valid <= 1'b0;
      irr_m     <= '0;
      irr_s     <= '0;
    end else if (take) begin
      vec_valid <= 1'b1;
      vec_data  <= next_vec;
      irr_m     <= one_hot(m_idx);
      irr_s     <= to_slave ? one_hot(s_idx) : '0;
    end
  end
endmodule

// File: rtl/irq_pair_ctrl.sv
module irq_pair_ctrl
  import irqp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [ADDRW-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NIN-2:0]   irq_m,
  input  logic [NIN-1:0]   irq_s,
  input  logic             vec_ready,
  output logic             vec_valid,
  output logic [DW-1:0]    vec_data
);
  logic [NIN-1:0] req_m_full;
  logic [DW-1:0]  m_rd_lo, m_rd_hi, s_rd_lo, s_rd_hi;
  logic           m_any, s_any;
  logic [IW-1:0]  m_idx, s_idx;
  logic [DW-1:0]  m_base, s_base;
  logic [NIN-1:0] m_mask, s_mask, m_latch, s_latch;
  logic [NIN-1:0] clr_m, clr_s, irr_m, irr_s;
  logic           take;
  logic           m_wr_lo, m_wr_hi, s_wr_lo, s_wr_hi;

  assign req_m_full = {1'b0, irq_m};
  assign m_wr_lo = bus_wr && !bus_addr[1] && !bus_addr[0];
  assign m_wr_hi = bus_wr && !bus_addr[1] &&  bus_addr[0];
  assign s_wr_lo = bus_wr &&  bus_addr[1] && !bus_addr[0];
  assign s_wr_hi = bus_wr &&  bus_addr[1] &&  bus_addr[0];

  irq_unit #(.HAS_CASC(1'b1)) u_master (
    .clk(clk), .rst_n(rst_n), .wr_lo(m_wr_lo), .wr_hi(m_wr_hi), .wdata(bus_wdata),
    .req_in(req_m_full), .casc_req(s_any), .clr(clr_m), .inflight(irr_m),
    .rd_lo(m_rd_lo), .rd_hi(m_rd_hi), .pend_any(m_any), .win_idx(m_idx),
    .base_o(m_base), .mask_o(m_mask), .latch_o(m_latch)
  );

  irq_unit #(.HAS_CASC(1'b0)) u_slave (
    .clk(clk), .rst_n(rst_n), .wr_lo(s_wr_lo), .wr_hi(s_wr_hi), .wdata(bus_wdata),
    .req_in(irq_s), .casc_req(1'b0), .clr(clr_s), .inflight(irr_s),
    .rd_lo(s_rd_lo), .rd_hi(s_rd_hi), .pend_any(s_any), .win_idx(s_idx),
    .base_o(s_base), .mask_o(s_mask), .latch_o(s_latch)
  );

  vec_issue u_issue (
    .clk(clk), .rst_n(rst_n), .m_any(m_any), .m_idx(m_idx), .m_base(m_base),
    .s_idx(s_idx), .s_base(s_base), .vec_ready(vec_ready), .vec_valid(vec_valid),
    .vec_data(vec_data), .take(take), .clr_m(clr_m), .clr_s(clr_s),
    .irr_m(irr_m), .irr_s(irr_s)
  );

  always_comb begin
    unique case (bus_addr)
      2'd0:    bus_rdata = m_rd_lo;
      2'd1:    bus_rdata = m_rd_hi;
      2'd2:    bus_rdata = s_rd_lo;
      default: bus_rdata = s_rd_hi;
    endcase
  end
endmodule

// File: rtl/irq_pair_chk.sv
module irq_pair_chk
  import irqp_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           vec_valid,
  input logic           vec_ready,
  input logic [DW-1:0]  vec_data,
  input logic           take,
  input logic [NIN-1:0] irr_m,
  input logic [NIN-1:0] irr_s,
  input logic [NIN-1:0] m_mask,
  input logic [NIN-1:0] m_latch,
  input logic [NIN-1:0] clr_m,
  input logic [NIN-1:0] req_m_full
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data)));

  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> !vec_valid);

  p_inflight_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irr_m) && $onehot0(irr_s) && (vec_valid || (irr_m == '0)));

  p_unmasked_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> ((irr_m & $past(m_mask)) == '0));

  p_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((m_latch & $past(clr_m & ~req_m_full)) == '0));
endmodule

bind irq_pair_ctrl irq_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
  .vec_data(vec_data), .take(take), .irr_m(irr_m), .irr_s(irr_s),
  .m_mask(m_mask), .m_latch(m_latch), .clr_m(clr_m), .req_m_full(req_m_full)
);

// File: tb/irq_pair_ctrl_test.sv
module irq_pair_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MBASE = 8'h40;
  localparam logic [7:0] SBASE = 8'h48;

  typedef struct packed {
    logic [7:0] mask_m;
    logic [7:0] mask_s;
    logic [6:0] req_m;
    logic [7:0] req_s;
    logic [7:0] expv;
  } row_t;

  localparam row_t TBL [6] = '{
    '{8'h00, 8'h00, 7'h0C, 8'h00, MBASE + 8'd2},
    '{8'h00, 8'h00, 7'h00, 8'h82, SBASE + 8'd1},
    '{8'h00, 8'h00, 7'h40, 8'h01, MBASE + 8'd6},
    '{8'h04, 8'h00, 7'h0C, 8'h00, MBASE + 8'd3},
    '{8'h80, 8'h00, 7'h20, 8'h10, MBASE + 8'd5},
    '{8'h00, 8'h02, 7'h00, 8'h06, SBASE + 8'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [6:0] irq_m = '0;
  logic [7:0] irq_s = '0;
  logic       vec_ready = 1'b0;
  logic       vec_valid;
  logic [7:0] vec_data;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_pair_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_m(irq_m), .irq_s(irq_s),
    .vec_ready(vec_ready), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [6:0] m, input logic [7:0] s);
    irq_m = m; irq_s = s;
    @(negedge clk);
    irq_m = '0; irq_s = '0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 8; i++) begin
      if (vec_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic expect_vec(input string tag, input logic [7:0] exp);
    wait_valid();
    chk({tag, " valid"}, {7'd0, vec_valid}, 8'h01);
    chk({tag, " vector"}, vec_data, exp);
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
  endtask

  task automatic drain();
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h00);
    for (int i = 0; i < 16; i++) begin
      vec_ready = vec_valid;
      @(negedge clk);
    end
    vec_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd1, r); chk("R1 primary mask", r, 8'hFF);
    rd(2'd3, r); chk("R1 secondary mask", r, 8'hFF);
    rd(2'd0, r); chk("R1 primary low read", r, 8'hFF);
    rd(2'd2, r); chk("R1 secondary low read", r, 8'hFF);
    chk("R1 no vector", {7'd0, vec_valid}, 8'h00);

    // R2 setup sequence; mid-sequence high writes must not touch the mask
    wr(2'd0, 8'h11);
    wr(2'd1, MBASE);
    rd(2'd1, r); chk("R2 mask after base word", r, 8'hFF);
    wr(2'd1, 8'h00);
    wr(2'd1, 8'h01);
    rd(2'd1, r); chk("R2 mask after last word", r, 8'hFF);
    wr(2'd2, 8'h11); wr(2'd3, SBASE); wr(2'd3, 8'h00); wr(2'd3, 8'h00);
    wr(2'd1, 8'h5A);
    rd(2'd1, r); chk("R2 mask loads after sequence", r, 8'h5A);
    wr(2'd1, 8'hFF);

    // R6 / R8 priority table
    foreach (TBL[k]) begin
      wr(2'd1, TBL[k].mask_m);
      wr(2'd3, TBL[k].mask_s);
      pulse(TBL[k].req_m, TBL[k].req_s);
      expect_vec($sformatf("R6 R8 row%0d", k), TBL[k].expv);
      drain();
    end
    wr(2'd1, 8'hFF); wr(2'd3, 8'hFF);

    // R5 masked request stays latched; R3 status select; R4 readback
    wr(2'd0, 8'h0B);
    wr(2'd1, 8'h01);
    pulse(7'h01, 8'h00);
    repeat (3) @(negedge clk);
    chk("R5 masked request no vector", {7'd0, vec_valid}, 8'h00);
    rd(2'd0, r); chk("R4 R5 latched read", r, 8'h01);
    wr(2'd0, 8'h20);
    rd(2'd0, r); chk("R3 non-select write ignored", r, 8'h01);
    wr(2'd0, 8'h0A);
    rd(2'd0, r); chk("R4 in-flight empty", r, 8'h00);
    wr(2'd1, 8'h00);
    @(negedge clk);
    chk("R10 valid after unmask", {7'd0, vec_valid}, 8'h01);
    chk("R10 vector after unmask", vec_data, MBASE);
    rd(2'd0, r); chk("R4 in-flight one-hot", r, 8'h01);
    wr(2'd0, 8'h0B);
    rd(2'd0, r); chk("R7 latch cleared on issue", r, 8'h00);
    wr(2'd0, 8'h08);
    rd(2'd0, r); chk("R4 other select reads ones", r, 8'hFF);
    vec_ready = 1'b1; @(negedge clk); vec_ready = 1'b0;

    // R9 hold while not ready, one idle cycle after accept
    pulse(7'h06, 8'h00);
    wait_valid();
    chk("R9 first vector", vec_data, MBASE + 8'd1);
    repeat (3) @(negedge clk);
    chk("R9 held valid", {7'd0, vec_valid}, 8'h01);
    chk("R9 held data", vec_data, MBASE + 8'd1);
    vec_ready = 1'b1; @(negedge clk); vec_ready = 1'b0;
    chk("R9 idle cycle", {7'd0, vec_valid}, 8'h00);
    @(negedge clk);
    chk("R9 next valid", {7'd0, vec_valid}, 8'h01);
    chk("R9 next vector", vec_data, MBASE + 8'd2);
    vec_ready = 1'b1; @(negedge clk); vec_ready = 1'b0;

    // R7 wrap of base plus index
    wr(2'd2, 8'h13); wr(2'd3, 8'hFC); wr(2'd3, 8'h00); wr(2'd3, 8'h00);
    wr(2'd3, 8'h00);
    pulse(7'h00, 8'h80);
    expect_vec("R7 wrap", 8'h03);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule